// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single timer channel. It counts elapsed ticks, where one tick is one cycle of the system clock with the `tick_en` input high. From that count it produces an output waveform that follows one of six operating behaviours. There are two one-shot styles, a rate generator, a square-wave generator and two strobe styles. A period is written as one 16-bit word with a single-cycle load strobe. The operating behaviour is taken live from a 3-bit mode input. A gate input either pauses counting or restarts the sequence, depending on the mode. The current count value and the output level are visible at all times.

Every pin is a plain control or status signal. The block has no streaming interface, so there is no back-pressure. A load is accepted in the cycle that its strobe is high, and it resets the elapsed count to zero. The mode input is expected to be stable from a load onward. After the mode changes, software is expected to write a new count.

In the requirements below, N is the loaded period and d is the number of ticks counted since the last load or restart.

Top module: `interval_timer_chan`

## Requirements
- R1: A loaded value of 0 gives a period N of 65536. Right after such a load the count reads 0x0000. After one counted tick it reads 0xFFFF, and in mode 0 the output is still low.
- R2: Mode 0 (code 0): the output is low while d < N and high once d >= N. It then stays high until the next load. The count reads (N − d) mod 65536.
- R3: Mode 1 (code 1): the output is low while d < N and high when d >= N. The count reads as in mode 0.
- R4: Mode 2 (code 2): the output is high only on ticks where d is a nonzero multiple of N. The count reads N − (d mod N), so it reloads to N at each multiple of N.
- R5: Mode 3 (code 3): the output is high while (d mod N) < (N+1)/2, using integer division, and low for the rest of each period. The count reads N − ((2·d) mod N).
- R6: Modes 4 and 5 (codes 4 and 5): the output is high only while d equals N, which lasts exactly one tick. The count reads as in mode 0.
- R7: In modes 1, 2, 3 and 5, a rising edge on `gate` sets d back to 0 in the next clock cycle, whether or not a tick is present.
- R8: In modes 0 and 4, ticks are ignored while `gate` is low, and the count and the output hold. A rising edge on `gate` does not restart the sequence in these modes.
- R9: In modes 0, 1, 4 and 5, the count keeps decrementing past zero, wrapping modulo 65536. It never reloads from N.
- R10: A load sets d to 0, and the first tick after the load makes d equal to 1. If a load and a tick arrive in the same cycle, the load takes priority and the tick is not counted.
- R11: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R12: After reset the channel behaves as if it had just been loaded with 0. The count reads 0x0000, and the output is low in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counting clock enable, one tick per high cycle |
| gate | input | 1 | Gate level; pauses counting or restarts the sequence, depending on the mode |
| load_en | input | 1 | Single-cycle strobe that loads `load_val` as the new period |
| load_val | input | 16 | New period; 0 means 65536 |
| mode | input | 3 | Operating mode code, 0 to 7 |
| count_o | output | 16 | Current visible count |
| out_o | output | 1 | Output level |

## Verification
The assertions check a set of local rules on every cycle:
- The internal remaining count never exceeds the period.
- A zero load yields the full 65536 period.
- The mode-0 output stays high once it has gone high.
- A mode-4 or mode-5 strobe falls after the single tick on which it rose.
- The count is frozen while the gate is low in modes 0 and 4.

Only the bench's scenarios can show the whole waveform of each mode against elapsed ticks. That covers the placement of the rate pulse, the square-wave duty and the count stepping by two for odd and even periods, and the restart from a gate edge partway through a period. It also covers the mode aliases, the wrap past zero, and a load that collides with a tick.

// File: rtl/itc_pkg.sv
package itc_pkg;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } itc_mode_e;

  // Codes 6 and 7 alias the periodic modes 2 and 3.
  function automatic itc_mode_e itc_norm(input logic [2:0] code);
    case (code)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return itc_mode_e'(code);
    endcase
  endfunction

  function automatic logic itc_periodic(input itc_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  // Modes in which the gate level qualifies counting instead of restarting.
  function automatic logic itc_gate_is_enable(input itc_mode_e m);
    return (m == M_TERM) || (m == M_SWSTB);
  endfunction

endpackage

// File: rtl/itc_gate_ctl.sv
module itc_gate_ctl
  import itc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      gate,
  input  logic      tick_en,
  input  itc_mode_e mode,
  output logic      cnt_en,
  output logic      restart
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  always_comb begin
    cnt_en  = tick_en && (gate || !itc_gate_is_enable(mode));
    restart = gate && !gate_q && !itc_gate_is_enable(mode);
  end

endmodule

// File: rtl/itc_phase.sv
module itc_phase
  import itc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         restart,
  input  logic         cnt_en,
  input  itc_mode_e    mode,
  output logic [W:0]   per_o,
  output logic [W:0]   rem_o,
  output logic [W:0]   vis_o,
  output logic         past_o,
  output logic         moved_o
);

  localparam int FW = W + 1;
  localparam logic [FW-1:0] FULL = FW'(1) << W;

  logic [FW-1:0] per_q, rem_q, vis_q;
  logic          past_q, moved_q;
  logic [FW-1:0] per_n, rem_n, vis_n, wrap_t;
  logic          past_n;

  always_comb begin
    per_n  = (load_val == '0) ? FULL : {1'b0, load_val};
    rem_n  = rem_q;
    vis_n  = vis_q;
    past_n = past_q;
    wrap_t = vis_q + per_q - FW'(2);
    if (itc_periodic(mode)) begin
      rem_n = (rem_q <= FW'(1)) ? per_q : rem_q - FW'(1);
      if (mode == M_SQUARE) begin
        if (vis_q > FW'(2)) vis_n = vis_q - FW'(2);
        else                vis_n = (wrap_t == '0) ? per_q : wrap_t;
      end
    end else begin
      if (rem_q == '0) past_n = 1'b1;
      else             rem_n  = rem_q - FW'(1);
      vis_n = {1'b0, vis_q[W-1:0] - W'(1)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= FULL;
      rem_q   <= FULL;
      vis_q   <= FULL;
      past_q  <= 1'b0;
      moved_q <= 1'b0;
    end else if (load || restart) begin
      if (load) per_q <= per_n;
      rem_q   <= load ? per_n : per_q;
      vis_q   <= load ? per_n : per_q;
      past_q  <= 1'b0;
      moved_q <= 1'b0;
    end else if (cnt_en) begin
      rem_q   <= rem_n;
      vis_q   <= vis_n;
      past_q  <= past_n;
      moved_q <= 1'b1;
    end
  end

  assign per_o   = per_q;
  assign rem_o   = rem_q;
  assign vis_o   = vis_q;
  assign past_o  = past_q;
  assign moved_o = moved_q;

  AST_LOAD_ZERO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (rem_q == FULL && per_q == FULL)); // R1

  AST_PHASE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= per_q); // R4

endmodule

// File: rtl/itc_out_dec.sv
module itc_out_dec
  import itc_pkg::*;
#(
  parameter int W = 16
) (
  input  itc_mode_e    mode,
  input  logic [W:0]   per,
  input  logic [W:0]   rem,
  input  logic [W:0]   vis,
  input  logic         past,
  input  logic         moved,
  output logic         out,
  output logic [W-1:0] count
);

  localparam int FW = W + 1;
  logic [FW-1:0] half;

  always_comb begin
    half = (per >> 1) + FW'(per[0]);
    case (mode)
      M_TERM, M_ONESHOT: begin
        out   = (rem == '0) || past;
        count = vis[W-1:0];
      end
      M_RATE: begin
        out   = moved && (rem == per);
        count = rem[W-1:0];
      end
      M_SQUARE: begin
        out   = rem > (per - half);
        count = vis[W-1:0];
      end
      default: begin
        out   = (rem == '0) && !past;
        count = vis[W-1:0];
      end
    endcase
  end

endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
  import itc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         gate,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [2:0]   mode,
  output logic [W-1:0] count_o,
  output logic         out_o
);

  localparam int FW = W + 1;

  itc_mode_e     mode_n;
  logic          cnt_en, restart, past, moved;
  logic [FW-1:0] per, rem, vis;

  assign mode_n = itc_norm(mode);

  itc_gate_ctl u_gate (
    .clk(clk), .rst_n(rst_n), .gate(gate), .tick_en(tick_en),
    .mode(mode_n), .cnt_en(cnt_en), .restart(restart)
  );

  itc_phase #(.W(W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_val(load_val),
    .restart(restart), .cnt_en(cnt_en), .mode(mode_n),
    .per_o(per), .rem_o(rem), .vis_o(vis), .past_o(past), .moved_o(moved)
  );

  itc_out_dec #(.W(W)) u_dec (
    .mode(mode_n), .per(per), .rem(rem), .vis(vis), .past(past),
    .moved(moved), .out(out_o), .count(count_o)
  );

  AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_n == M_TERM && out_o && !load_en) |=> (out_o || itc_norm(mode) != M_TERM)); // R2

  AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_n == M_SWSTB || mode_n == M_HWSTB) && out_o && cnt_en && !load_en && !restart)
      |=> (!out_o || !(itc_norm(mode) == M_SWSTB || itc_norm(mode) == M_HWSTB))); // R6

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (itc_gate_is_enable(mode_n) && !gate && !load_en)
      |=> (mode != $past(mode) || count_o == $past(count_o))); // R8

endmodule

// File: tb/interval_timer_chan_tb.sv
module interval_timer_chan_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate = 1'b1;
  logic        load_en = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] count_o;
  logic        out_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model of the channel state: period, elapsed ticks, effective mode.
  int n_m = 65536;
  int d_m = 0;
  int mode_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load_en(load_en), .load_val(load_val), .mode(mode),
    .count_o(count_o), .out_o(out_o)
  );

  function automatic int eff_mode(input int c);
    return (c >= 6) ? c - 4 : c;
  endfunction

  function automatic int exp_count(input int m, input int n, input int d);
    case (m)
      2:       return (n - (d % n)) & 16'hFFFF;
      3:       return (n - ((2 * d) % n)) & 16'hFFFF;
      default: return (n - d) & 16'hFFFF;
    endcase
  endfunction

  function automatic bit exp_out(input int m, input int n, input int d);
    case (m)
      0, 1:    return d >= n;
      2:       return (d % n == 0) && (d != 0);
      3:       return (d % n) < ((n + 1) / 2);
      default: return d == n;
    endcase
  endfunction

  task automatic check_state(input string req);
    int ec;
    bit eo;
    ec = exp_count(mode_m, n_m, d_m);
    eo = exp_out(mode_m, n_m, d_m);
    n_chk++;
    if (count_o !== 16'(ec)) begin
      n_fail++;
      $display("FAIL %s count d=%0d: got %0h expected %0h", req, d_m, count_o, ec);
    end
    n_chk++;
    if (out_o !== eo) begin
      n_fail++;
      $display("FAIL %s out d=%0d: got %0b expected %0b", req, d_m, out_o, eo);
    end
  endtask

  task automatic do_load(input int m, input int v, input string req);
    @(negedge clk);
    mode = 3'(m); load_val = 16'(v); load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    mode_m = eff_mode(m);
    n_m = (v == 0) ? 65536 : v;
    d_m = 0;
    check_state(req);
  endtask

  task automatic do_ticks(input int k, input string req);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      if (gate || !(mode_m == 0 || mode_m == 4)) d_m++;
      check_state(req);
    end
  endtask

  task automatic set_gate(input bit v, input string req);
    bit rise;
    @(negedge clk);
    rise = v && !gate;
    gate = v;
    @(negedge clk);
    if (rise && !(mode_m == 0 || mode_m == 4)) d_m = 0;
    check_state(req);
  endtask

  task automatic t_reset;    // R12
    n_m = 65536; d_m = 0; mode_m = 0;
    check_state("R12");
  endtask

  task automatic t_mode0;    // R2, R9
    do_load(0, 5, "R2");
    do_ticks(5, "R2");
    do_ticks(3, "R9");
  endtask

  task automatic t_gate_enable;  // R8
    do_load(4, 6, "R8");
    do_ticks(2, "R8");
    set_gate(1'b0, "R8");
    do_ticks(3, "R8");
    set_gate(1'b1, "R8");
    do_ticks(5, "R6");
  endtask

  task automatic t_mode1;    // R3, R7
    do_load(1, 4, "R3");
    do_ticks(2, "R3");
    set_gate(1'b0, "R3");
    set_gate(1'b1, "R7");
    do_ticks(5, "R3");
  endtask

  task automatic t_mode2;    // R4, R7
    do_load(2, 3, "R4");
    do_ticks(8, "R4");
    set_gate(1'b0, "R4");
    set_gate(1'b1, "R7");
    do_ticks(4, "R4");
    do_load(2, 1, "R4");
    do_ticks(3, "R4");
  endtask

  task automatic t_mode3;    // R5
    do_load(3, 5, "R5");
    do_ticks(11, "R5");
    do_load(3, 4, "R5");
    do_ticks(9, "R5");
  endtask

  task automatic t_strobe5;  // R6, R7
    do_load(5, 2, "R6");
    do_ticks(3, "R6");
    set_gate(1'b0, "R6");
    set_gate(1'b1, "R7");
    do_ticks(3, "R6");
  endtask

  task automatic t_alias;    // R11
    do_load(6, 3, "R11");
    do_ticks(7, "R11");
    do_load(7, 5, "R11");
    do_ticks(6, "R11");
  endtask

  task automatic t_zero;     // R1
    do_load(0, 0, "R1");
    do_ticks(2, "R1");
  endtask

  task automatic t_collide;  // R10
    do_load(0, 9, "R10");
    do_ticks(3, "R10");
    @(negedge clk);
    load_val = 16'd4; load_en = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0; tick_en = 1'b0;
    n_m = 4; d_m = 0;
    check_state("R10");
    do_ticks(1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_gate_enable();
    t_mode1();
    t_mode2();
    t_mode3();
    t_strobe5();
    t_alias();
    t_zero();
    t_collide();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule